// File: doc/BRIEF.md
# Service Link Request Frame Decoder

This block watches the master-to-slave direction of a clocked, electrically inverted serial service link and turns each request frame into parallel fields. A system-clock strobe `sample_en` marks every rising edge of the link clock, and the line level captured then is inverted to give the logical bit. A frame opens with a logical 1. The decoder then collects a slave number and a command prefix code whose length varies. Depending on the command it goes on to take a direction bit, an optional sign bit, an address whose length depends on the command, a data-size bit, write data and a 4-bit check code.

Absolute addresses are reported as received. Relative and same-address requests are resolved against an address cached separately for each of the four slaves. A cache entry is written only when the frame's check code was correct and the response side later confirms the request with `ack_in`; response decoding itself is done elsewhere. When a frame completes, `frm_valid` pulses for one cycle. `crc_ok` pulses with it if the check code matched. Malformed frames pulse `frm_err` instead.

Top module: `svc_req_decoder`

## Requirements
- R1: A line bit counts only in a cycle where `sample_en` is 1, and the logical bit is the inverse of `line_in`. In idle, logical 0 bits are skipped and a logical 1 starts a frame. The next two bits form `slave_id`: the first received bit is bit 0 and the second is bit 1.
- R2: Command prefixes are shifted in first bit first and matched against 11 (same-address) after two bits, and against 100 (absolute), 101 (relative), 010, 011 and 001 (the three poll kinds) after three bits. `cmd` reports them as 0 absolute, 1 relative, 2 same-address, 3/4/5 for polls 010/011/001, and 6 terminate.
- R3: If no prefix has matched by the 8th command bit, `frm_err` pulses one cycle after that bit is sampled, no `frm_valid` follows, and the decoder returns to idle.
- R4: Address commands carry a direction bit next (1 = read, reported on `is_read`). The address follows first bit first: 21 bits for absolute, 8 for relative, 2 for same-address. An absolute address appears unchanged on `addr`.
- R5: A relative frame has a sign bit between the direction bit and its address. The result is the cached address plus the 8-bit value when the sign is 0, or the cached address minus (256 − value) when the sign is 1, modulo 2^21.
- R6: A same-address frame keeps bits 20..2 of the cached address and takes bits 1..0 from the received two bits.
- R7: A relative or same-address frame aimed at a slave with no valid cache entry sets `resolve_err` and reports the received value as `addr`. `resolve_err` is 0 for every other frame.
- R8: Data-size bit 0 means byte (`size` = 0). Bit 1 with received address bits 1..0 = 01 means word (`size` = 2), with `addr` bits 1..0 forced to 01. Bit 1 with received address bit 0 = 0 means halfword (`size` = 1), with `addr` bit 0 cleared.
- R9: A write whose received address bits 1..0 are 11 and whose data-size bit is 1 pulses `frm_err` one cycle after the size bit and returns to idle.
- R10: A read whose received address bits 1..0 are 11 and whose data-size bit is 1 becomes a terminate request. `cmd` is 6, `is_read` is 0, and the check code follows at once.
- R11: Writes carry 8, 16 or 32 data bits (byte, halfword, word), first bit most significant, zero-extended on `wdata`. Reads, polls and terminate requests carry no data.
- R12: The 4-bit check code is sent first bit first. It is compared with a register cleared at the start bit and stepped over every bit from the start bit through the last payload bit, using fb = c[3] ^ bit and next = {c[2], c[1]^fb, c[0]^fb, fb}. `crc_ok` pulses with `frm_valid` only on a match.
- R13: After an absolute, relative or same-address frame with `crc_ok`, an `ack_in` pulse before the next start bit writes that frame's final `addr` into the cache entry of its slave and marks it valid. Frames with a bad check code, other frames, and other slaves' entries are left unchanged.
- R14: `frm_valid` is a one-cycle pulse one clock after the last check bit is sampled. It never coincides with `frm_err`, and both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe at each rising link-clock edge |
| line_in | input | 1 | Raw link data level (inverted logic) |
| ack_in | input | 1 | Pulse: the last request was acknowledged |
| frm_valid | output | 1 | Pulse: frame complete, fields valid |
| frm_err | output | 1 | Pulse: malformed command or size |
| crc_ok | output | 1 | Pulse with frm_valid when the check code matched |
| slave_id | output | 2 | Target slave number |
| cmd | output | 3 | Decoded command |
| is_read | output | 1 | Direction, 1 = read |
| addr | output | 21 | Resolved and size-adjusted address |
| size | output | 2 | 0 byte, 1 halfword, 2 word |
| wdata | output | 32 | Write data, zero-extended |
| resolve_err | output | 1 | Relative/same-address target had no cached base |

## Verification
The paths that are hardest to reach from the ports all depend on cache state built up by earlier frames. Relative wrap-around below zero and same-address merging only happen once a good-code frame has been acknowledged. A bad-code frame followed by an acknowledge must leave the cache untouched. The stimulus first primes the entries of chosen slaves with directed frames and acknowledges. It then runs a seeded random mix of commands, corrupted check codes and acknowledges against a bench model of the four entries. That mix also produces terminate, size-error and invalid-prefix frames along the way.

// File: rtl/svcreq_pkg.sv
package svcreq_pkg;

   typedef enum logic [2:0] {
      CMD_ABS   = 3'd0,
      CMD_REL   = 3'd1,
      CMD_SAME  = 3'd2,
      CMD_DPOLL = 3'd3,
      CMD_EPOLL = 3'd4,
      CMD_IPOLL = 3'd5,
      CMD_TERM  = 3'd6,
      CMD_NONE  = 3'd7
   } cmd_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } size_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SID,
      ST_CMD,
      ST_DIR,
      ST_SIGN,
      ST_ADDR,
      ST_SIZE,
      ST_WDATA,
      ST_CRC
   } state_e;

   // Prefix matcher: only the last three bits and the bit count matter.
   function automatic cmd_e match_prefix(input logic [2:0] tail,
                                         input logic at2,
                                         input logic at3);
      cmd_e r;
      r = CMD_NONE;
      if (at2 && tail[1:0] == 2'b11) begin
         r = CMD_SAME;
      end else if (at3) begin
         case (tail)
            3'b100:  r = CMD_ABS;
            3'b101:  r = CMD_REL;
            3'b010:  r = CMD_DPOLL;
            3'b011:  r = CMD_EPOLL;
            3'b001:  r = CMD_IPOLL;
            default: r = CMD_NONE;
         endcase
      end
      return r;
   endfunction

   function automatic logic is_addr_cmd(input cmd_e c);
      return (c == CMD_ABS) || (c == CMD_REL) || (c == CMD_SAME);
   endfunction

endpackage

// File: rtl/svcreq_crc.sv
module svcreq_crc #(
   parameter int             W    = 4,
   parameter logic [W-1:0]   POLY = 'h7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         restart,
   input  logic         din,
   output logic [W-1:0] crc
);

   if (W < 2) begin : g_bad_w
      $error("svcreq_crc: W must be at least 2");
   end

   logic [W-1:0] base;
   logic [W-1:0] nxt;
   logic         fb;

   always_comb begin
      base = restart ? '0 : crc;
      fb   = base[W-1] ^ din;
      nxt  = {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc <= '0;
      end else if (step) begin
         crc <= nxt;
      end
   end

endmodule

// File: rtl/svcreq_cache.sv
module svcreq_cache #(
   parameter int ID_W   = 2,
   parameter int ADDR_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ID_W-1:0]   rd_id,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_ok
);

   localparam int SLAVES = 1 << ID_W;

   logic [SLAVES-1:0][ADDR_W-1:0] ent;
   logic [SLAVES-1:0]             ok;

   for (genvar g = 0; g < SLAVES; g++) begin : g_ent
      logic [ADDR_W-1:0] val_q;
      logic              vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= '0;
            vld_q <= 1'b0;
         end else if (wr_en && wr_id == ID_W'(g)) begin
            val_q <= wr_addr;
            vld_q <= 1'b1;
         end
      end

      assign ent[g] = val_q;
      assign ok[g]  = vld_q;
   end

   assign rd_addr = ent[rd_id];
   assign rd_ok   = ok[rd_id];

endmodule

// File: rtl/svcreq_resolve.sv
module svcreq_resolve
   import svcreq_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int REL_W  = 8,
   parameter int SAME_W = 2
) (
   input  cmd_e              cmd,
   input  logic              neg,
   input  logic [ADDR_W-1:0] raw,
   input  logic [ADDR_W-1:0] base,
   input  logic              base_ok,
   output logic [ADDR_W-1:0] addr,
   output logic              miss
);

   localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(1) << REL_W;

   always_comb begin
      addr = raw;
      miss = 1'b0;
      if (cmd == CMD_REL || cmd == CMD_SAME) begin
         if (!base_ok) begin
            miss = 1'b1;
         end else if (cmd == CMD_REL) begin
            addr = base + ADDR_W'(raw[REL_W-1:0]) - (neg ? SPAN : '0);
         end else begin
            addr = {base[ADDR_W-1:SAME_W], raw[SAME_W-1:0]};
         end
      end
   end

endmodule

// File: rtl/svc_req_decoder.sv
module svc_req_decoder
   import svcreq_pkg::*;
#(
   parameter int               ID_W     = 2,
   parameter int               ADDR_W   = 21,
   parameter int               REL_W    = 8,
   parameter int               SAME_W   = 2,
   parameter int               DATA_W   = 32,
   parameter int               CMD_MAX  = 8,
   parameter int               CRC_W    = 4,
   parameter logic [CRC_W-1:0] CRC_POLY = 4'h7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_en,
   input  logic              line_in,
   input  logic              ack_in,
   output logic              frm_valid,
   output logic              frm_err,
   output logic              crc_ok,
   output logic [ID_W-1:0]   slave_id,
   output logic [2:0]        cmd,
   output logic              is_read,
   output logic [ADDR_W-1:0] addr,
   output logic [1:0]        size,
   output logic [DATA_W-1:0] wdata,
   output logic              resolve_err
);

   localparam int LEN_A  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
   localparam int LEN_B  = (LEN_A > CMD_MAX) ? LEN_A : CMD_MAX;
   localparam int MAXLEN = (LEN_B > CRC_W) ? LEN_B : CRC_W;
   localparam int CNT_W  = $clog2(MAXLEN + 1);

   if (ID_W < 1 || SAME_W < 2 || REL_W < 2 || REL_W >= ADDR_W ||
       SAME_W > ADDR_W || CMD_MAX < 3 || CRC_W < 2 ||
       DATA_W < 8 || (DATA_W % 4) != 0) begin : g_bad_cfg
      $error("svc_req_decoder: unsupported parameter set");
   end

   state_e            st;
   cmd_e              cmd_q;
   cmd_e              hit;
   size_e             sz_q;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_n;
   logic              bit_in;
   logic [2:0]        tail;
   logic [2:0]        tail_n;
   logic              neg_q;
   logic [ADDR_W-1:0] raw_q;
   logic [ADDR_W-1:0] raw_n;
   logic [CRC_W-1:0]  rx_q;
   logic [CRC_W-1:0]  rx_n;
   logic [CRC_W-1:0]  lfsr;
   logic              lfsr_step;
   logic              pend_q;
   logic [ID_W-1:0]   pend_id;
   logic [ADDR_W-1:0] pend_addr;
   logic [ADDR_W-1:0] base;
   logic              base_ok;
   logic [ADDR_W-1:0] res_addr;
   logic              res_miss;

   function automatic logic [CNT_W-1:0] addr_len(input cmd_e c);
      case (c)
         CMD_REL:  return CNT_W'(REL_W);
         CMD_SAME: return CNT_W'(SAME_W);
         default:  return CNT_W'(ADDR_W);
      endcase
   endfunction

   function automatic logic [CNT_W-1:0] data_len(input size_e s);
      case (s)
         SZ_BYTE: return CNT_W'(DATA_W / 4);
         SZ_HALF: return CNT_W'(DATA_W / 2);
         default: return CNT_W'(DATA_W);
      endcase
   endfunction

   assign bit_in    = ~line_in;
   assign cnt_n     = cnt + 1'b1;
   assign tail_n    = {tail[1:0], bit_in};
   assign raw_n     = {raw_q[ADDR_W-2:0], bit_in};
   assign rx_n      = {rx_q[CRC_W-2:0], bit_in};
   assign hit       = match_prefix(tail_n, cnt_n == CNT_W'(2), cnt_n == CNT_W'(3));
   assign lfsr_step = sample_en && ((st == ST_IDLE) ? bit_in : (st != ST_CRC));
   assign cmd       = cmd_q;
   assign size      = sz_q;

   svcreq_crc #(
      .W    (CRC_W),
      .POLY (CRC_POLY)
   ) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (lfsr_step),
      .restart (st == ST_IDLE),
      .din     (bit_in),
      .crc     (lfsr)
   );

   svcreq_cache #(
      .ID_W   (ID_W),
      .ADDR_W (ADDR_W)
   ) u_cache (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ack_in && pend_q),
      .wr_id   (pend_id),
      .wr_addr (pend_addr),
      .rd_id   (slave_id),
      .rd_addr (base),
      .rd_ok   (base_ok)
   );

   svcreq_resolve #(
      .ADDR_W (ADDR_W),
      .REL_W  (REL_W),
      .SAME_W (SAME_W)
   ) u_resolve (
      .cmd     (cmd_q),
      .neg     (neg_q),
      .raw     (raw_n),
      .base    (base),
      .base_ok (base_ok),
      .addr    (res_addr),
      .miss    (res_miss)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         cmd_q       <= CMD_NONE;
         sz_q        <= SZ_BYTE;
         cnt         <= '0;
         tail        <= '0;
         neg_q       <= 1'b0;
         raw_q       <= '0;
         rx_q        <= '0;
         pend_q      <= 1'b0;
         pend_id     <= '0;
         pend_addr   <= '0;
         frm_valid   <= 1'b0;
         frm_err     <= 1'b0;
         crc_ok      <= 1'b0;
         slave_id    <= '0;
         is_read     <= 1'b0;
         addr        <= '0;
         wdata       <= '0;
         resolve_err <= 1'b0;
      end else begin
         frm_valid <= 1'b0;
         frm_err   <= 1'b0;
         crc_ok    <= 1'b0;
         if (ack_in && pend_q) begin
            pend_q <= 1'b0;
         end
         if (sample_en) begin
            unique case (st)
               ST_IDLE: begin
                  if (bit_in) begin
                     st          <= ST_SID;
                     cnt         <= '0;
                     slave_id    <= '0;
                     cmd_q       <= CMD_NONE;
                     sz_q        <= SZ_BYTE;
                     is_read     <= 1'b0;
                     resolve_err <= 1'b0;
                     pend_q      <= 1'b0;
                  end
               end
               ST_SID: begin
                  slave_id <= (slave_id >> 1) | (ID_W'(bit_in) << (ID_W - 1));
                  cnt      <= cnt_n;
                  if (cnt_n == CNT_W'(ID_W)) begin
                     st   <= ST_CMD;
                     cnt  <= '0;
                     tail <= '0;
                  end
               end
               ST_CMD: begin
                  tail <= tail_n;
                  cnt  <= cnt_n;
                  if (hit != CMD_NONE) begin
                     cmd_q <= hit;
                     cnt   <= '0;
                     raw_q <= '0;
                     st    <= is_addr_cmd(hit) ? ST_DIR : ST_CRC;
                  end else if (cnt_n == CNT_W'(CMD_MAX)) begin
                     frm_err <= 1'b1;
                     st      <= ST_IDLE;
                  end
               end
               ST_DIR: begin
                  is_read <= bit_in;
                  st      <= (cmd_q == CMD_REL) ? ST_SIGN : ST_ADDR;
               end
               ST_SIGN: begin
                  neg_q <= bit_in;
                  st    <= ST_ADDR;
               end
               ST_ADDR: begin
                  raw_q <= raw_n;
                  cnt   <= cnt_n;
                  if (cnt_n == addr_len(cmd_q)) begin
                     addr        <= res_addr;
                     resolve_err <= res_miss;
                     st          <= ST_SIZE;
                  end
               end
               ST_SIZE: begin
                  cnt   <= '0;
                  wdata <= '0;
                  if (is_read && raw_q[1:0] == 2'b11 && bit_in) begin
                     cmd_q   <= CMD_TERM;
                     is_read <= 1'b0;
                     st      <= ST_CRC;
                  end else if (!bit_in) begin
                     sz_q <= SZ_BYTE;
                     st   <= is_read ? ST_CRC : ST_WDATA;
                  end else if (raw_q[1:0] == 2'b01) begin
                     sz_q      <= SZ_WORD;
                     addr[1:0] <= 2'b01;
                     st        <= is_read ? ST_CRC : ST_WDATA;
                  end else if (!raw_q[0]) begin
                     sz_q    <= SZ_HALF;
                     addr[0] <= 1'b0;
                     st      <= is_read ? ST_CRC : ST_WDATA;
                  end else begin
                     frm_err <= 1'b1;
                     st      <= ST_IDLE;
                  end
               end
               ST_WDATA: begin
                  wdata <= {wdata[DATA_W-2:0], bit_in};
                  cnt   <= cnt_n;
                  if (cnt_n == data_len(sz_q)) begin
                     cnt <= '0;
                     st  <= ST_CRC;
                  end
               end
               ST_CRC: begin
                  rx_q <= rx_n;
                  cnt  <= cnt_n;
                  if (cnt_n == CNT_W'(CRC_W)) begin
                     frm_valid <= 1'b1;
                     crc_ok    <= (rx_n == lfsr);
                     st        <= ST_IDLE;
                     if (rx_n == lfsr && is_addr_cmd(cmd_q)) begin
                        pend_q    <= 1'b1;
                        pend_id   <= slave_id;
                        pend_addr <= addr;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

module svcreq_checker #(
   parameter int ADDR_W = 21
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sample_en,
   input logic              frm_valid,
   input logic              frm_err,
   input logic              crc_ok,
   input logic [2:0]        cmd,
   input logic              is_read,
   input logic [ADDR_W-1:0] addr,
   input logic [1:0]        size,
   input logic              resolve_err
);

   a_r14_valid_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> !frm_err);

   a_r14_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> !frm_valid);

   a_r12_crc_ok_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      crc_ok |-> frm_valid);

   a_r1_strobe_before_event: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid || frm_err) |-> $past(sample_en));

   a_r8_word_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && size == 2'd2 && cmd <= 3'd2) |-> (addr[1:0] == 2'b01));

   a_r8_half_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && size == 2'd1 && cmd <= 3'd2) |-> !addr[0]);

   a_r10_term_not_read: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && cmd == 3'd6) |-> !is_read);

   a_r7_abs_never_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && cmd == 3'd0) |-> !resolve_err);

endmodule

bind svc_req_decoder svcreq_checker #(.ADDR_W(ADDR_W)) u_svcreq_checker (.*);

// File: tb/test_svc_req_decoder.sv
`timescale 1ns/1ps
module test_svc_req_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_en = 1'b0;
   logic        line_in = 1'b1;
   logic        ack_in = 1'b0;
   logic        frm_valid;
   logic        frm_err;
   logic        crc_ok;
   logic [1:0]  slave_id;
   logic [2:0]  cmd;
   logic        is_read;
   logic [20:0] addr;
   logic [1:0]  size;
   logic [31:0] wdata;
   logic        resolve_err;

   svc_req_decoder i_svc_req_decoder (.*);

   always #10 clk = ~clk;

   int          n_chk = 0;
   int          n_bad = 0;
   logic [20:0] mc [4];
   bit          mv [4];
   bit          last_ok = 0;
   int          last_sid = 0;
   logic [20:0] last_addr = '0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_bit(input bit b);
      @(negedge clk);
      line_in   = ~b;
      sample_en = 1'b1;
      @(negedge clk);
      sample_en = 1'b0;
      line_in   = 1'($urandom);
   endtask

   function automatic logic [3:0] crc_of(input bit q[$]);
      logic [3:0] c;
      bit fb;
      c = 4'h0;
      foreach (q[i]) begin
         fb = c[3] ^ q[i];
         c  = {c[2:0], 1'b0} ^ (fb ? 4'h7 : 4'h0);
      end
      return c;
   endfunction

   task automatic do_ack();
      @(negedge clk);
      ack_in = 1'b1;
      @(negedge clk);
      ack_in = 1'b0;
      if (last_ok) begin
         mc[last_sid] = last_addr;
         mv[last_sid] = 1'b1;
      end
      last_ok = 0;
   endtask

   // kind: 0 abs, 1 rel, 2 same, 3/4/5 polls
   task automatic do_frame(input int sid, input int kind, input bit rd, input bit neg,
                           input logic [20:0] raw_in, input bit szb,
                           input logic [31:0] wd, input bit corrupt);
      bit          q[$];
      logic [20:0] raw;
      logic [20:0] ea;
      logic [31:0] m;
      logic [3:0]  c;
      int          alen;
      int          dlen;
      int          esz;
      int          ecmd;
      bit          eread;
      bit          er;
      bit          serr;
      q.push_back(1'b1);
      q.push_back(sid[0]);
      q.push_back(sid[1]);
      case (kind)
         0: begin q.push_back(1); q.push_back(0); q.push_back(0); end
         1: begin q.push_back(1); q.push_back(0); q.push_back(1); end
         2: begin q.push_back(1); q.push_back(1); end
         3: begin q.push_back(0); q.push_back(1); q.push_back(0); end
         4: begin q.push_back(0); q.push_back(1); q.push_back(1); end
         default: begin q.push_back(0); q.push_back(0); q.push_back(1); end
      endcase
      ecmd = kind; eread = 0; esz = 0; dlen = 0; serr = 0; er = 0; ea = '0; raw = '0;
      if (kind < 3) begin
         eread = rd;
         alen  = (kind == 0) ? 21 : (kind == 1) ? 8 : 2;
         raw   = raw_in & ((21'd1 << alen) - 21'd1);
         q.push_back(rd);
         if (kind == 1) q.push_back(neg);
         for (int i = alen - 1; i >= 0; i--) q.push_back(raw[i]);
         if (kind == 0) ea = raw;
         else if (!mv[sid]) begin ea = raw; er = 1; end
         else if (kind == 1) ea = neg ? mc[sid] - (21'h100 - raw) : mc[sid] + raw;
         else ea = {mc[sid][20:2], raw[1:0]};
         q.push_back(szb);
         if (rd && raw[1:0] == 2'b11 && szb) begin ecmd = 6; eread = 0; end
         else if (!szb) esz = 0;
         else if (raw[1:0] == 2'b01) begin esz = 2; ea[1:0] = 2'b01; end
         else if (!raw[0]) begin esz = 1; ea[0] = 1'b0; end
         else serr = 1;
         if (!serr && ecmd != 6 && !rd) begin
            dlen = (esz == 0) ? 8 : (esz == 1) ? 16 : 32;
            for (int i = dlen - 1; i >= 0; i--) q.push_back(wd[i]);
         end
      end
      last_ok = 0;
      if (serr) begin
         foreach (q[i]) send_bit(q[i]);
         chk("R9 size error pulse", frm_err, 1);
         chk("R9 no valid on size error", frm_valid, 0);
         return;
      end
      c = crc_of(q);
      if (corrupt) c[0] = ~c[0];
      for (int i = 3; i >= 0; i--) q.push_back(c[i]);
      foreach (q[i]) send_bit(q[i]);
      chk("R14 valid pulse", frm_valid, 1);
      chk("R14 no err with valid", frm_err, 0);
      chk("R12 crc_ok", crc_ok, !corrupt);
      chk("R1 slave id", slave_id, sid);
      chk((ecmd == 6) ? "R10 terminate cmd" : "R2 cmd code", cmd, ecmd);
      chk((ecmd == 6) ? "R10 terminate not read" : "R4 direction", is_read, eread);
      chk("R7 resolve flag", resolve_err, er);
      if (kind < 3) begin
         chk((kind == 1) ? "R5 relative addr" : (kind == 2) ? "R6 same addr" : "R4 abs addr",
             addr, ea);
         if (ecmd != 6) chk("R8 size code", size, esz);
         if (dlen != 0) begin
            m = (dlen == 32) ? 32'hFFFF_FFFF : ((32'd1 << dlen) - 32'd1);
            chk("R11 write data", wdata, wd & m);
         end
         last_ok   = !corrupt && ecmd != 6;
         last_sid  = sid;
         last_addr = ea;
      end
   endtask

   task automatic bad_cmd(input int sid);
      bit q[$];
      q.push_back(1'b1);
      q.push_back(sid[0]);
      q.push_back(sid[1]);
      repeat (3) q.push_back(1'b0);
      repeat (5) q.push_back(1'($urandom));
      for (int i = 0; i < q.size() - 1; i++) send_bit(q[i]);
      chk("R3 no early error", frm_err, 0);
      send_bit(q[q.size() - 1]);
      chk("R3 invalid prefix error", frm_err, 1);
      chk("R3 no valid", frm_valid, 0);
      last_ok = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'h5EED_0042;
      void'($urandom(seed));
      for (int i = 0; i < 4; i++) begin mc[i] = '0; mv[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R14 reset valid", frm_valid, 0);
      chk("R14 reset err", frm_err, 0);
      chk("R12 reset crc_ok", crc_ok, 0);
      // idle zeros and ignored toggles (R1)
      repeat (4) send_bit(1'b0);
      chk("R1 idle zeros no event", frm_valid | frm_err, 0);

      do_frame(2, 1, 0, 0, 21'h33, 0, 32'hA5, 0);         // R7 miss
      do_frame(1, 0, 0, 0, 21'h12344, 0, 32'h5C, 0);
      do_ack();
      do_frame(1, 1, 1, 0, 21'h10, 0, 0, 0);              // R5 +
      do_frame(1, 1, 0, 1, 21'hF0, 1, 32'hBEEF, 0);       // R5 -, half
      do_frame(1, 2, 0, 0, 21'h1, 1, 32'hDEADBEEF, 0);    // R6 word
      do_frame(1, 0, 0, 0, 21'h700, 0, 32'h11, 1);        // bad code
      do_ack();                                           // R13 no write
      do_frame(1, 2, 1, 0, 21'h2, 0, 0, 0);
      chk("R13 cache unchanged after bad code", addr, 21'h12346);
      do_frame(3, 2, 1, 0, 21'h1, 0, 0, 0);               // R7 other slave
      do_frame(1, 2, 1, 0, 21'h3, 1, 0, 0);               // R10 terminate
      do_frame(1, 0, 0, 0, 21'h7, 1, 0, 0);               // R9 size error
      do_frame(0, 3, 0, 0, 0, 0, 0, 0);
      do_frame(0, 4, 0, 0, 0, 0, 0, 0);
      do_frame(3, 5, 0, 0, 0, 0, 0, 0);
      bad_cmd(2);
      do_frame(0, 0, 1, 0, 21'h5, 0, 0, 0);
      do_ack();
      do_frame(0, 1, 1, 1, 21'hF0, 0, 0, 0);              // R5 wrap
      chk("R5 wrap below zero", addr, 21'h1FFFF5);

      for (int n = 0; n < 250; n++) begin
         int k;
         k = int'($urandom % 7);
         if (k == 6) bad_cmd(int'($urandom % 4));
         else do_frame(int'($urandom % 4), k, 1'($urandom), 1'($urandom),
                       21'($urandom), 1'($urandom), $urandom,
                       ($urandom % 6) == 0);
         if ($urandom % 2) do_ack();
         if ($urandom % 4 == 0) send_bit(1'b0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule